// File: doc/BRIEF.md
# Two-phase CCD readout clock sequencer

This block produces the digital levels for the clock lines of a full-frame CCD that has two vertical phases (V1, V2) and two horizontal phases (H1, H2). A one-cycle `start` pulse, accepted only when the sequencer is idle, captures the exposure length, the row and column counts and the dwell times. The sequencer then holds the array in integration with both vertical clocks low. After that it alternates two activities until every row is read. The first is a four-step vertical move that carries one row into the horizontal register. The second is a complementary horizontal readout of that row.

The states and their transitions are as follows. `S_IDLE` goes to `S_INTEG` on start. `S_INTEG` goes to `S_VMERGE`, or to `S_DONE` when the row count is zero. The vertical steps run in order: `S_VMERGE` (V1 high), `S_VSWAP` (V2 high, which pushes the line into the horizontal register), `S_VBACK` (V1 high) and `S_VCLOSE` (both low). `S_VCLOSE` goes to `S_HPUSH` when the column count is non-zero. Otherwise it goes to the next row's `S_VMERGE`, or to `S_DONE` after the last row. Each pixel runs `S_HPUSH` (H2 high), then `S_HDROP` (H1 high). `S_HDROP` goes back to `S_HPUSH` for the next pixel, to `S_VMERGE` for the next row, or to `S_DONE` after the last pixel of the last row. `S_DONE` lasts one cycle and returns to `S_IDLE`.

A dwell value of N gives a step of N+1 system clock cycles. The reset-gate pulse clears the output node during the H2-high half-period. It always drops before H2 falls.

Top module: `ccd_clock_sequencer`

## Requirements
- R1: After synchronous reset, and in idle, the outputs are V1=0, V2=0, H1=1, H2=0, reset gate 0, pixel-valid 0 and frame-done 0.
- R2: A start pulse in idle begins integration on the next cycle. Integration lasts exposure+1 cycles with V1=V2=0, H1=1 and H2=0.
- R3: Each row transfer runs four steps of v_dwell+1 cycles each, with (V1,V2) = (1,0), (0,1), (1,0), (0,0) in that order. H1=1 and H2=0 hold throughout.
- R4: Each pixel drives H2=1 with H1=0 for h_dwell+1 cycles, then H1=1 with H2=0 for h_dwell+1 cycles. H1 and H2 are never both high.
- R5: Pixel-valid is high for exactly one cycle: the first cycle after each H2 falling edge. This gives n_cols pulses per row.
- R6: The reset gate is high for the first min(rg_width, h_dwell) cycles of each H2-high half-period. It is low in the last H2-high cycle and whenever H2 is low.
- R7: Row transfer and readout repeat for n_rows rows. After the last row, frame-done is high for one cycle, and the sequencer then returns to idle.
- R8: With n_rows=0, frame-done follows integration directly. With n_cols=0, each row performs only the vertical steps, with no horizontal clocking.
- R9: A start pulse while a frame is running is ignored, and input values that change during a frame have no effect on that frame.
- R10: Reset asserted in the middle of a frame returns all outputs to the idle levels on the next cycle. A later start begins a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame start strobe, accepted in idle only |
| exposure | input | EXP_W (24) | Integration length minus one, in cycles |
| n_rows | input | ROW_W (12) | Number of rows to read |
| n_cols | input | COL_W (12) | Number of pixels per row |
| v_dwell | input | DWELL_W (8) | Vertical step length minus one |
| h_dwell | input | DWELL_W (8) | Horizontal half-period length minus one |
| rg_width | input | DWELL_W (8) | Reset-gate pulse width in cycles |
| v1 | output | 1 | Vertical phase 1 clock |
| v2 | output | 1 | Vertical phase 2 clock |
| h1 | output | 1 | Horizontal phase 1 clock |
| h2 | output | 1 | Horizontal phase 2 clock |
| rg | output | 1 | Reset-gate pulse |
| pix_valid | output | 1 | One-cycle strobe after each H2 fall |
| frame_done | output | 1 | One-cycle end-of-frame flag |

## Verification
Two cases can fall in the same cycle.

The first is the end of a wide reset-gate pulse and the H2 falling edge. Frames with rg_width equal to or larger than h_dwell, and with h_dwell of zero, provoke it. The judgement is that the gate is already low in the last H2-high cycle and that pixel-valid appears only in the following cycle.

The second is a start pulse and a busy sequencer, including the one-cycle done state. Random frames provoke it by re-pulsing start and scrambling every input at each cycle of the frame. The cycle-by-cycle trace must still follow the values captured at the original start.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_INTEG,
        S_VMERGE,
        S_VSWAP,
        S_VBACK,
        S_VCLOSE,
        S_HPUSH,
        S_HDROP,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic v1;
        logic v2;
        logic h1;
        logic h2;
        logic rg;
        logic pix;
        logic done;
    } clk_lines_t;

endpackage

// File: rtl/ccd_dwell_timer.sv
module ccd_dwell_timer #(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [TW-1:0] limit,
    output logic [TW-1:0] count,
    output logic          expired
);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

    assign expired = (count == limit);

    AST_TIMER_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        count <= limit); // R2

endmodule

// File: rtl/ccd_line_counters.sv
module ccd_line_counters #(
    parameter int ROW_W = 12,
    parameter int COL_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] rows_in,
    input  logic [COL_W-1:0] cols_in,
    input  logic             col_reload,
    input  logic             col_dec,
    input  logic             row_dec,
    output logic             rows_none,
    output logic             row_last,
    output logic             cols_none,
    output logic             col_last
);

    logic [ROW_W-1:0] rows_left;
    logic [COL_W-1:0] cols_cfg;
    logic [COL_W-1:0] cols_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            rows_left <= '0;
            cols_cfg  <= '0;
            cols_left <= '0;
        end else if (load) begin
            rows_left <= rows_in;
            cols_cfg  <= cols_in;
            cols_left <= cols_in;
        end else begin
            if (row_dec) begin
                rows_left <= rows_left - 1'b1;
            end
            if (col_reload) begin
                cols_left <= cols_cfg;
            end else if (col_dec) begin
                cols_left <= cols_left - 1'b1;
            end
        end
    end

    assign rows_none = (rows_left == '0);
    assign row_last  = (rows_left == ROW_W'(1));
    assign cols_none = (cols_cfg == '0);
    assign col_last  = (cols_left == COL_W'(1));

    AST_ROW_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        row_dec |-> !rows_none); // R7
    AST_COL_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        col_dec |-> (cols_left != '0)); // R5

endmodule

// File: rtl/ccd_seq_fsm.sv
module ccd_seq_fsm
    import ccd_seq_pkg::*;
#(
    parameter int EXP_W   = 24,
    parameter int DWELL_W = 8,
    parameter int TW      = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [EXP_W-1:0]   exposure,
    input  logic [DWELL_W-1:0] v_dwell,
    input  logic [DWELL_W-1:0] h_dwell,
    input  logic [DWELL_W-1:0] rg_width,
    input  logic [TW-1:0]      t_count,
    input  logic               t_expired,
    input  logic               rows_none,
    input  logic               row_last,
    input  logic               cols_none,
    input  logic               col_last,
    output logic [TW-1:0]      t_limit,
    output logic               t_restart,
    output logic               cnt_load,
    output logic               col_reload,
    output logic               col_dec,
    output logic               row_dec,
    output clk_lines_t         lines
);

    seq_state_t         state;
    seq_state_t         state_nx;
    logic [EXP_W-1:0]   exp_q;
    logic [DWELL_W-1:0] vd_q;
    logic [DWELL_W-1:0] hd_q;
    logic [DWELL_W-1:0] rgw_q;

    // state register and captured configuration
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            exp_q <= '0;
            vd_q  <= '0;
            hd_q  <= '0;
            rgw_q <= '0;
        end else begin
            state <= state_nx;
            if (cnt_load) begin
                exp_q <= exposure;
                vd_q  <= v_dwell;
                hd_q  <= h_dwell;
                rgw_q <= rg_width;
            end
        end
    end

    // timer limit for the running step
    always_comb begin
        unique case (state)
            S_INTEG:                               t_limit = TW'(exp_q);
            S_VMERGE, S_VSWAP, S_VBACK, S_VCLOSE:  t_limit = TW'(vd_q);
            S_HPUSH, S_HDROP:                      t_limit = TW'(hd_q);
            default:                               t_limit = '0;
        endcase
    end

    // next state and counter strobes
    always_comb begin
        state_nx   = state;
        cnt_load   = 1'b0;
        col_reload = 1'b0;
        col_dec    = 1'b0;
        row_dec    = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    state_nx = S_INTEG;
                    cnt_load = 1'b1;
                end
            end
            S_INTEG: begin
                if (t_expired) begin
                    state_nx = rows_none ? S_DONE : S_VMERGE;
                end
            end
            S_VMERGE: if (t_expired) state_nx = S_VSWAP;
            S_VSWAP:  if (t_expired) state_nx = S_VBACK;
            S_VBACK:  if (t_expired) state_nx = S_VCLOSE;
            S_VCLOSE: begin
                if (t_expired) begin
                    if (cols_none) begin
                        row_dec  = 1'b1;
                        state_nx = row_last ? S_DONE : S_VMERGE;
                    end else begin
                        col_reload = 1'b1;
                        state_nx   = S_HPUSH;
                    end
                end
            end
            S_HPUSH: if (t_expired) state_nx = S_HDROP;
            S_HDROP: begin
                if (t_expired) begin
                    col_dec = 1'b1;
                    if (col_last) begin
                        row_dec  = 1'b1;
                        state_nx = row_last ? S_DONE : S_VMERGE;
                    end else begin
                        state_nx = S_HPUSH;
                    end
                end
            end
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    assign t_restart = t_expired || (state == S_IDLE) || (state == S_DONE);

    // clock line levels decoded from the state register
    always_comb begin
        lines    = '0;
        lines.h1 = 1'b1;
        unique case (state)
            S_VMERGE: lines.v1 = 1'b1;
            S_VSWAP:  lines.v2 = 1'b1;
            S_VBACK:  lines.v1 = 1'b1;
            S_HPUSH: begin
                lines.h1 = 1'b0;
                lines.h2 = 1'b1;
                lines.rg = (t_count < TW'(rgw_q)) && (t_count < TW'(hd_q));
            end
            S_HDROP: lines.pix  = (t_count == '0);
            S_DONE:  lines.done = 1'b1;
            default: ;
        endcase
    end

    AST_H_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(lines.h1 && lines.h2)); // R4
    AST_V_HOLDS_H: assert property (@(posedge clk) disable iff (rst)
        (lines.v1 || lines.v2) |-> (lines.h1 && !lines.h2)); // R3
    AST_V_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(lines.v1 && lines.v2)); // R3
    AST_PIX_AFTER_H2_FALL: assert property (@(posedge clk) disable iff (rst)
        lines.pix |-> ($past(lines.h2) && !lines.h2)); // R5
    AST_RG_CLEAR_OF_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(lines.h2) |-> (!$past(lines.rg) && !lines.rg)); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lines.done |=> (!lines.done && state == S_IDLE)); // R7
    AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && state != S_INTEG) |=> (state != S_INTEG)); // R9

endmodule

// File: rtl/ccd_clock_sequencer.sv
module ccd_clock_sequencer
    import ccd_seq_pkg::*;
#(
    parameter int EXP_W   = 24,
    parameter int ROW_W   = 12,
    parameter int COL_W   = 12,
    parameter int DWELL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [EXP_W-1:0]   exposure,
    input  logic [ROW_W-1:0]   n_rows,
    input  logic [COL_W-1:0]   n_cols,
    input  logic [DWELL_W-1:0] v_dwell,
    input  logic [DWELL_W-1:0] h_dwell,
    input  logic [DWELL_W-1:0] rg_width,
    output logic               v1,
    output logic               v2,
    output logic               h1,
    output logic               h2,
    output logic               rg,
    output logic               pix_valid,
    output logic               frame_done
);

    localparam int TW = (EXP_W > DWELL_W) ? EXP_W : DWELL_W;

    logic [TW-1:0] t_limit;
    logic [TW-1:0] t_count;
    logic          t_expired;
    logic          t_restart;
    logic          cnt_load;
    logic          col_reload;
    logic          col_dec;
    logic          row_dec;
    logic          rows_none;
    logic          row_last;
    logic          cols_none;
    logic          col_last;
    clk_lines_t    lines;

    ccd_dwell_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (t_restart),
        .limit   (t_limit),
        .count   (t_count),
        .expired (t_expired)
    );

    ccd_line_counters #(.ROW_W(ROW_W), .COL_W(COL_W)) u_counters (
        .clk        (clk),
        .rst        (rst),
        .load       (cnt_load),
        .rows_in    (n_rows),
        .cols_in    (n_cols),
        .col_reload (col_reload),
        .col_dec    (col_dec),
        .row_dec    (row_dec),
        .rows_none  (rows_none),
        .row_last   (row_last),
        .cols_none  (cols_none),
        .col_last   (col_last)
    );

    ccd_seq_fsm #(.EXP_W(EXP_W), .DWELL_W(DWELL_W), .TW(TW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .exposure   (exposure),
        .v_dwell    (v_dwell),
        .h_dwell    (h_dwell),
        .rg_width   (rg_width),
        .t_count    (t_count),
        .t_expired  (t_expired),
        .rows_none  (rows_none),
        .row_last   (row_last),
        .cols_none  (cols_none),
        .col_last   (col_last),
        .t_limit    (t_limit),
        .t_restart  (t_restart),
        .cnt_load   (cnt_load),
        .col_reload (col_reload),
        .col_dec    (col_dec),
        .row_dec    (row_dec),
        .lines      (lines)
    );

    assign v1         = lines.v1;
    assign v2         = lines.v2;
    assign h1         = lines.h1;
    assign h2         = lines.h2;
    assign rg         = lines.rg;
    assign pix_valid  = lines.pix;
    assign frame_done = lines.done;

endmodule

// File: tb/ccd_clock_sequencer_test.sv
module ccd_clock_sequencer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] exposure = '0;
    logic [11:0] n_rows = '0;
    logic [11:0] n_cols = '0;
    logic [7:0]  v_dwell = '0;
    logic [7:0]  h_dwell = '0;
    logic [7:0]  rg_width = '0;
    logic        v1, v2, h1, h2, rg, pix_valid, frame_done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit poke   = 1'b0;

    always #4 clk = ~clk;

    ccd_clock_sequencer uut (
        .clk(clk), .rst(rst), .start(start), .exposure(exposure),
        .n_rows(n_rows), .n_cols(n_cols), .v_dwell(v_dwell),
        .h_dwell(h_dwell), .rg_width(rg_width), .v1(v1), .v2(v2),
        .h1(h1), .h2(h2), .rg(rg), .pix_valid(pix_valid),
        .frame_done(frame_done)
    );

    // vector order: v1 v2 h1 h2 rg pix_valid frame_done
    localparam logic [6:0] IDLE_V = 7'b0010000;
    localparam logic [6:0] DONE_V = 7'b0010001;

    function automatic logic [6:0] vstep(input int k);
        case (k)
            0: return 7'b1010000;
            1: return 7'b0110000;
            2: return 7'b1010000;
            default: return 7'b0010000;
        endcase
    endfunction

    function automatic logic [6:0] hpush(input int k, input int hd, input int rgw);
        logic g;
        g = (k < rgw) && (k < hd);
        return {4'b0001, g, 2'b00};
    endfunction

    function automatic logic [6:0] hdrop(input int k);
        return {5'b00100, (k == 0), 1'b0};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic tick(input logic [6:0] expv, input string tag);
        logic [6:0] act;
        @(negedge clk);
        act = {v1, v2, h1, h2, rg, pix_valid, frame_done};
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s cycle %0d: actual=%b expected=%b", tag, cyc, act, expv);
        end
        if (poke) begin
            start    = 1'($urandom);
            exposure = 24'($urandom);
            n_rows   = 12'($urandom);
            n_cols   = 12'($urandom);
            v_dwell  = 8'($urandom);
            h_dwell  = 8'($urandom);
            rg_width = 8'($urandom);
        end else begin
            start = 1'b0;
        end
    endtask

    task automatic run_frame(input int e, input int r, input int c, input int vd,
                             input int hd, input int rgw, input bit pk);
        @(negedge clk);
        exposure = 24'(e); n_rows = 12'(r); n_cols = 12'(c);
        v_dwell = 8'(vd); h_dwell = 8'(hd); rg_width = 8'(rgw);
        start = 1'b1;
        poke  = pk;
        for (int i = 0; i <= e; i++) tick(IDLE_V, "R2");
        for (int row = 0; row < r; row++) begin
            for (int s = 0; s < 4; s++)
                for (int i = 0; i <= vd; i++) tick(vstep(s), (c == 0) ? "R8" : "R3");
            for (int col = 0; col < c; col++) begin
                for (int i = 0; i <= hd; i++) tick(hpush(i, hd, rgw), "R6");
                for (int i = 0; i <= hd; i++) tick(hdrop(i), "R5");
            end
        end
        tick(DONE_V, (r == 0) ? "R8" : "R7");
        poke = 1'b0;
        tick(IDLE_V, "R7");
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick(IDLE_V, "R1");
        tick(IDLE_V, "R1");

        // directed corner cases
        run_frame(2, 2, 3, 1, 2, 1, 1'b0);   // R4 basic two-row readout
        run_frame(0, 0, 5, 0, 0, 0, 1'b0);   // R8 zero rows
        run_frame(1, 3, 0, 2, 1, 1, 1'b0);   // R8 zero columns
        run_frame(0, 1, 2, 0, 2, 7, 1'b0);   // R6 wide reset gate clamped
        run_frame(3, 2, 2, 0, 0, 3, 1'b0);   // R6 zero h_dwell, no gate
        run_frame(1, 2, 2, 1, 1, 1, 1'b1);   // R9 start and inputs scrambled

        // R10 reset in the middle of a frame
        @(negedge clk);
        exposure = 24'd1; n_rows = 12'd3; n_cols = 12'd3;
        v_dwell = 8'd1; h_dwell = 8'd1; rg_width = 8'd1;
        start = 1'b1;
        tick(IDLE_V, "R2");
        tick(IDLE_V, "R2");
        tick(vstep(0), "R3");
        tick(vstep(0), "R3");
        rst = 1'b1;
        tick(IDLE_V, "R10");
        rst = 1'b0;
        tick(IDLE_V, "R10");
        run_frame(0, 1, 1, 0, 1, 1, 1'b0);   // R10 fresh frame after reset

        // constrained random frames
        for (int n = 0; n < 40; n++) begin
            run_frame(int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
                      int'($urandom_range(0, 4)), int'($urandom_range(0, 3)),
                      int'($urandom_range(0, 3)), int'($urandom_range(0, 4)),
                      1'($urandom));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule